// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches one 16-bit word from a small three-wire serial EEPROM holding 64 words. A host hands it a 6-bit word address through a valid/ready request port. The block selects the memory and sends a 9-bit read frame, most significant bit first. The frame is a leading one, the two-bit read opcode `10` and the six address bits. It then clocks sixteen data bits in, MSB first, and deselects the memory. It closes the access with one extra clock pulse while the memory is deselected.

The serial clock is derived from the system clock. Each half of a serial clock period lasts `HALF_CYC` system cycles. The default suits a slow memory that needs tens of microseconds between clock edges. The request port applies back-pressure: `req_ready` is low for the whole access, and a request offered while it is low is neither taken nor queued. The result port has no back-pressure. `done` is a one-cycle valid strobe, and the consumer must capture `rd_data` then or later, before the next access ends, because `rd_data` holds until that point.

A typical user reads all 64 words after power-up. It then checks that adding every word to a start value of 0xBABA gives 0xBABA again, which is the same as the words summing to zero modulo 2^16.

Top module: `mw_eeprom_reader`

## Requirements
- R1: After reset `ee_cs`, `ee_sk`, `ee_di`, `busy` and `done` are low, `req_ready` is high and `rd_data` is zero. Whenever `busy` is low, `ee_cs` and `ee_sk` are low.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `busy` is high from the next cycle on, and `req_ready` equals the inverse of `busy`.
- R3: While selected, the block sends 9 frame bits MSB first: 1, 1, 0, then address bits 5 down to 0. Each bit is on `ee_di` before the rising edge of `ee_sk` and stays unchanged while `ee_sk` is high.
- R4: Each high phase and each low phase of `ee_sk` lasts `HALF_CYC` system clock cycles. A whole access keeps `busy` high for exactly 52 × `HALF_CYC` cycles.
- R5: On each of the 16 rising `ee_sk` edges after the frame, the memory presents one data bit, MSB first. The block samples `ee_do` at the end of each high phase, and `rd_data` bit 15 is the first bit sampled.
- R6: `ee_cs` falls together with the falling `ee_sk` edge that ends the last data bit. Exactly one more `ee_sk` pulse follows with `ee_cs` low, so each access has 26 rising edges in total. The block is then idle.
- R7: `done` is high for exactly one cycle. In that cycle `busy` falls and `rd_data` carries the new word. `rd_data` changes only in a `done` cycle.
- R8: A request offered while `busy` is high is ignored. It starts no second frame and does not alter the word returned by the access in progress.
- R9: Any address from 0 to 63 can be read, back to back, and a sweep of all 64 words returns the stored contents, whose sum with 0xBABA gives 0xBABA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Block can take a request (idle) |
| req_addr | input | 6 | Word address of the request |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle strobe: `rd_data` valid |
| rd_data | output | 16 | Last word read |
| ee_cs | output | 1 | Memory chip select, active high |
| ee_sk | output | 1 | Serial clock to the memory |
| ee_di | output | 1 | Serial data into the memory |
| ee_do | input | 1 | Serial data from the memory |

## Verification
The bench models the memory on the serial pins. It decodes every frame it receives and counts clock pulses with select high and with select low. A design that got the frame order wrong, or that sent eight or ten command bits, would return the wrong word or misalign every data bit. A design that dropped the trailing pulse, or kept select high through it, shows up in the pulse count taken with select low. Addresses 0 and 63, the all-zero and all-one patterns, a request held high during a busy access, and the exact busy length are checked separately. A divider off by one, or a lost handshake, changes a measured cycle count or produces a second frame.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_DATA = 2'd2,
    ST_TAIL = 2'd3
  } mw_state_e;

  localparam logic [2:0] MW_READ_OP = 3'b110;
endpackage

// File: rtl/mw_half_timer.sv
module mw_half_timer #(
  parameter int HALF_CYC = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (HALF_CYC < 2) ? 1 : $clog2(HALF_CYC);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RELOAD;
    end else if (!run || cnt_q == '0) begin
      cnt_q <= RELOAD;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/mw_seq.sv
module mw_seq
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic              tick,
  input  logic              ee_do,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di
);
  localparam int CMD_W = 3 + ADDR_W;
  localparam int MAXB  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
  localparam int BC_W  = $clog2(MAXB);

  mw_state_e         state_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [DATA_W-1:0] dat_q;
  logic [BC_W-1:0]   bit_q;

  assign busy = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      dat_q   <= '0;
      bit_q   <= '0;
      rd_data <= '0;
      done    <= 1'b0;
      ee_cs   <= 1'b0;
      ee_sk   <= 1'b0;
      ee_di   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_CMD;
            ee_cs   <= 1'b1;
            ee_sk   <= 1'b0;
            ee_di   <= MW_READ_OP[2];
            cmd_q   <= {MW_READ_OP[1:0], addr, 1'b0};
            bit_q   <= BC_W'(CMD_W - 1);
          end
        end
        ST_CMD: begin
          if (tick) begin
            if (!ee_sk) begin
              ee_sk <= 1'b1;
            end else begin
              ee_sk <= 1'b0;
              if (bit_q == '0) begin
                state_q <= ST_DATA;
                ee_di   <= 1'b0;
                bit_q   <= BC_W'(DATA_W - 1);
              end else begin
                bit_q <= bit_q - 1'b1;
                ee_di <= cmd_q[CMD_W-1];
                cmd_q <= {cmd_q[CMD_W-2:0], 1'b0};
              end
            end
          end
        end
        ST_DATA: begin
          if (tick) begin
            if (!ee_sk) begin
              ee_sk <= 1'b1;
            end else begin
              ee_sk <= 1'b0;
              dat_q <= {dat_q[DATA_W-2:0], ee_do};
              if (bit_q == '0) begin
                state_q <= ST_TAIL;
                ee_cs   <= 1'b0;
              end else begin
                bit_q <= bit_q - 1'b1;
              end
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            if (!ee_sk) begin
              ee_sk <= 1'b1;
            end else begin
              ee_sk   <= 1'b0;
              state_q <= ST_IDLE;
              done    <= 1'b1;
              rd_data <= dat_q;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader #(
  parameter int HALF_CYC = 5000,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);
  logic tick;
  logic start;

  assign req_ready = !busy;
  assign start     = req_valid && req_ready;

  mw_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .tick  (tick)
  );

  mw_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .addr    (req_addr),
    .tick    (tick),
    .ee_do   (ee_do),
    .busy    (busy),
    .done    (done),
    .rd_data (rd_data),
    .ee_cs   (ee_cs),
    .ee_sk   (ee_sk),
    .ee_di   (ee_di)
  );
endmodule

// File: rtl/mw_eeprom_reader_chk.sv
module mw_eeprom_reader_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] rd_data,
  input logic              ee_cs,
  input logic              ee_sk,
  input logic              ee_di
);
  localparam int RISES = 26;

  logic       sk_d;
  logic [5:0] rise_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_d     <= 1'b0;
      rise_cnt <= '0;
    end else begin
      sk_d <= ee_sk;
      if (req_valid && req_ready) rise_cnt <= '0;
      else if (ee_sk && !sk_d)    rise_cnt <= rise_cnt + 1'b1;
    end
  end

  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ee_cs && !ee_sk));

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  p_di_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_cs && ee_sk && $past(ee_sk)) |-> $stable(ee_di));

  p_pulse_total_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rise_cnt == 6'(RISES)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rd_data));

  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy || done || $past(done)));
endmodule

bind mw_eeprom_reader mw_eeprom_reader_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .busy      (busy),
  .done      (done),
  .rd_data   (rd_data),
  .ee_cs     (ee_cs),
  .ee_sk     (ee_sk),
  .ee_di     (ee_di)
);

// File: tb/sim_mw_eeprom_reader.sv
`timescale 1ns/1ps
module sim_mw_eeprom_reader;
  localparam int HALF = 2;
  localparam int PER  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_addr = '0;
  logic        busy, done;
  logic [15:0] rd_data;
  logic        ee_cs, ee_sk, ee_di;
  logic        ee_do = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;

  always #(PER/2) clk = ~clk;

  mw_eeprom_reader #(.HALF_CYC(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .busy(busy), .done(done), .rd_data(rd_data),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  // Memory model on the serial pins
  logic [15:0] mem [64];
  logic [8:0]  frame_sh;
  logic [8:0]  last_frame;
  int          sel_rises, tail_rises, frames, di_bad;
  realtime     t_prev, period;

  always @(posedge ee_cs) begin
    sel_rises  = 0;
    tail_rises = 0;
    frame_sh   = '0;
  end

  always @(posedge ee_sk) begin
    if (ee_cs) begin
      sel_rises = sel_rises + 1;
      if (sel_rises > 1) period = $realtime - t_prev;
      t_prev = $realtime;
      if (sel_rises <= 9) begin
        frame_sh = {frame_sh[7:0], ee_di};
        if (sel_rises == 9) begin
          frames     = frames + 1;
          last_frame = frame_sh;
        end
      end else if (sel_rises <= 25) begin
        ee_do = mem[frame_sh[5:0]][15 - (sel_rises - 10)];
      end
    end else begin
      tail_rises = tail_rises + 1;
    end
  end

  // R3: data-in must not move while the clock is high
  always @(ee_di) if (ee_cs && ee_sk) di_bad = di_bad + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [5:0] a, output logic [15:0] w, output int bcyc);
    bcyc = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) begin
      if (busy) bcyc++;
      @(negedge clk);
    end
    w = rd_data;
  endtask

  task automatic t_reset;
    check("R1 cs", ee_cs, 0);
    check("R1 sk", ee_sk, 0);
    check("R1 di", ee_di, 0);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 ready", req_ready, 1);
    check("R1 data", rd_data, 0);
  endtask

  task automatic t_single(input logic [5:0] a);
    logic [15:0] w; int bc; int f0;
    f0 = frames;
    do_read(a, w, bc);
    check("R5 word", w, mem[a]);
    check("R3 frame", last_frame, {3'b110, a});
    check("R3 frames", frames - f0, 1);
    check("R6 tail pulses", tail_rises, 1);
    check("R6 selected pulses", sel_rises, 25);
    check("R4 busy length", bc, 52*HALF);
    check("R4 sk period", int'(period), 2*HALF*PER);
    check("R7 done width", done, 1);
    @(negedge clk);
    check("R7 done drops", done, 0);
    check("R1 idle pins", {ee_cs, ee_sk}, 0);
    check("R2 ready back", req_ready, 1);
  endtask

  task automatic t_accept;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 6'd5;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 busy after accept", busy, 1);
    check("R2 ready low", req_ready, 0);
    while (!done) @(negedge clk);
    check("R5 accept word", rd_data, mem[5]);
  endtask

  task automatic t_busy_ignore;
    int f0;
    f0 = frames;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 6'd17;
    @(negedge clk);
    req_addr = 6'd40;
    repeat (20) @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    check("R8 word of first request", rd_data, mem[17]);
    check("R8 frame address", last_frame, {3'b110, 6'd17});
    repeat (10) @(negedge clk);
    check("R8 single frame", frames - f0, 1);
    check("R8 no restart", busy, 0);
    check("R7 data held", rd_data, mem[17]);
  endtask

  task automatic t_sweep;
    logic [15:0] w, sum; int bc, bad;
    sum = 16'hBABA; bad = 0;
    for (int i = 0; i < 64; i++) begin
      do_read(6'(i), w, bc);
      if (w !== mem[i]) bad++;
      sum = sum + w;
    end
    check("R9 sweep mismatches", bad, 0);
    check("R9 checksum", sum, 16'hBABA);
  endtask

  initial begin
    logic [15:0] acc;
    acc = '0;
    frames = 0; di_bad = 0; sel_rises = 0; tail_rises = 0;
    t_prev = 0; period = 0;
    for (int i = 0; i < 62; i++) begin
      mem[i] = 16'(i * 16'h0B3D + 16'h1234);
      acc = acc + mem[i];
    end
    mem[10] = 16'h0000; mem[20] = 16'hFFFF;
    acc = '0;
    for (int i = 0; i < 62; i++) acc = acc + mem[i];
    mem[62] = 16'h8001;
    acc = acc + mem[62];
    mem[63] = 16'(-acc);
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_single(6'd0);
    t_single(6'd63);
    t_single(6'd10);
    t_single(6'd20);
    t_single(6'd42);
    t_accept;
    t_busy_ignore;
    t_sweep;
    check("R3 di steady while sk high", di_bad, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(PER * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule